// File: doc/BRIEF.md
# Keyboard and Mouse Interrupt Hold

This block sits between an input-device controller and the interrupt controller. It keeps the keyboard interrupt (IRQ1) and the mouse interrupt (IRQ12) asserted after the source pulse has gone away. A hold is released only when the host reads the controller data port. Software would otherwise miss short source pulses that arrive while the interrupt controller is busy. Holding each line until the data is fetched closes that gap.

Each channel has its own enable. While a channel is disabled, its request output follows the raw source level. Disabling a channel drops any held request at once. The block also answers reads of the data port, but only while at least one channel is enabled. A hard reset clears both held bits and loads each enable from a platform strap input.

Channel index 0 is the keyboard (IRQ1) and channel index 1 is the mouse (IRQ12) in every two-bit vector port.

Top module: `input_irq_hold`

## Requirements
- R1: With channel 0 (keyboard) enabled, a high `src_irq[0]` at a clock edge makes `irq_req[0]` high from the next cycle, and it stays high after the source falls.
- R2: With channel 1 (mouse) enabled, a high `src_irq[1]` at a clock edge makes `irq_req[1]` high from the next cycle, and it stays high after the source falls.
- R3: A claimed read (`io_rd` high, `io_addr` equal to 0x0060) clears, at the next edge, the held bit of every enabled channel whose source is low, and leaves disabled channels untouched.
- R4: During a claimed read, `rd_claim` is 1 and `rd_data` is 0xFF in the same cycle.
- R5: While both enables are 0, a read of 0x0060 gives `rd_claim` = 0 and `rd_data` = 0x00 and changes no state.
- R6: Writing 0 to a channel enable (`en_we[i]` = 1, `en_val[i]` = 0) clears that channel's held bit at the next edge, so its held request is gone from the next cycle.
- R7: While a channel is disabled, its `irq_req` equals its `src_irq` in the same cycle.
- R8: If a channel's source is high in the same cycle as a claimed read, the set wins and the request stays held.
- R9: Synchronous reset (`rst` = 1) clears both held bits and loads each enable from `strap_en[i]`.
- R10: Reads at any address other than 0x0060 are not claimed (`rd_claim` = 0, `rd_data` = 0x00) and release no held request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| strap_en | input | 2 | Platform strap: enable value loaded at reset, per channel |
| en_we | input | 2 | Per-channel enable write strobe |
| en_val | input | 2 | Per-channel enable value written with `en_we` |
| src_irq | input | 2 | Raw interrupt levels from the input controller |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O read address |
| irq_req | output | 2 | Interrupt requests towards the interrupt controller |
| rd_claim | output | 1 | High when this block serves the current read |
| rd_data | output | 8 | Read data, 0xFF when claimed, 0x00 otherwise |

## Verification
The first set of tests uses single-cycle source pulses followed by quiet cycles. This separates a true hold from a plain passthrough. Data-port reads are issued with one channel, both channels and no channel enabled, which shows that the clear is gated per channel and that the claim depends on any enable being set. Two further cases catch a wrong priority or a loose address compare: a source pulse on the same cycle as the read, and reads at a neighbouring address. A long stretch of random strobes, enables and sources is also compared cycle by cycle against a behavioural model.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;

    localparam int N_CH   = 2;
    localparam int CH_KBD = 0;
    localparam int CH_AUX = 1;

    typedef struct packed {
        logic en;
        logic held;
    } chan_state_t;

    function automatic logic next_held(input logic en_next, input logic src,
                                       input logic held_now, input logic release_rd);
        logic keep;
        keep = held_now & ~release_rd;
        return en_next & (src | keep);
    endfunction

endpackage

// File: rtl/irq_hold_decode.sv
module irq_hold_decode #(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0060
) (
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              any_en,
    output logic              claim,
    output logic [DATA_W-1:0] data
);
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    always_comb begin
        claim = io_rd && (io_addr == PORT_ADDR) && any_en;
        data  = claim ? ALL_ONES : '0;
    end
endmodule

// File: rtl/irq_hold_chan.sv
module irq_hold_chan
    import irq_hold_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strap,
    input  logic en_we,
    input  logic en_val,
    input  logic src,
    input  logic release_rd,
    output logic en_o,
    output logic req_o
);
    chan_state_t state_q;
    chan_state_t state_d;

    always_comb begin
        state_d.en   = en_we ? en_val : state_q.en;
        state_d.held = next_held(state_d.en, src, state_q.held, release_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.en   <= strap;
            state_q.held <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_o  = state_q.en;
    assign req_o = state_q.en ? state_q.held : src;

    // R1 / R2: an enabled source sets the hold
    p_hold_set_r1: assert property (@(posedge clk) disable iff (rst)
        (state_d.en && src) |=> state_q.held);

    // R3: a release read with quiet source clears the hold
    p_release_r3: assert property (@(posedge clk) disable iff (rst)
        (release_rd && !src) |=> !state_q.held);

    // R8: set and release in the same cycle keeps the request
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (release_rd && src && state_d.en) |=> state_q.held);

    // R6: turning the channel off drops the hold
    p_disable_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (en_we && !en_val) |=> (!state_q.held && !state_q.en));
endmodule

// File: rtl/input_irq_hold.sv
module input_irq_hold
    import irq_hold_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0060
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   strap_en,
    input  logic [N_CH-1:0]   en_we,
    input  logic [N_CH-1:0]   en_val,
    input  logic [N_CH-1:0]   src_irq,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    output logic [N_CH-1:0]   irq_req,
    output logic              rd_claim,
    output logic [DATA_W-1:0] rd_data
);
    logic [N_CH-1:0] en_vec;
    logic            claim;

    irq_hold_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PORT_ADDR(PORT_ADDR)
    ) decode_i (
        .io_rd  (io_rd),
        .io_addr(io_addr),
        .any_en (|en_vec),
        .claim  (claim),
        .data   (rd_data)
    );

    assign rd_claim = claim;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        irq_hold_chan chan_i (
            .clk       (clk),
            .rst       (rst),
            .strap     (strap_en[ch]),
            .en_we     (en_we[ch]),
            .en_val    (en_val[ch]),
            .src       (src_irq[ch]),
            .release_rd(claim),
            .en_o      (en_vec[ch]),
            .req_o     (irq_req[ch])
        );
    end

    // R5: the port is served only while some channel is enabled
    p_claim_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        rd_claim |-> (en_vec != '0));

    // R4: served reads return all ones
    p_claim_data_r4: assert property (@(posedge clk) disable iff (rst)
        rd_claim |-> (rd_data == {DATA_W{1'b1}}));

    // R10: a read elsewhere is never claimed
    p_other_addr_r10: assert property (@(posedge clk) disable iff (rst)
        (io_addr != PORT_ADDR) |-> !rd_claim);
endmodule

// File: tb/input_irq_hold_tb_top.sv
`timescale 1ns/1ps
module input_irq_hold_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  strap_en = 2'b11;
    logic [1:0]  en_we = 2'b00;
    logic [1:0]  en_val = 2'b00;
    logic [1:0]  src_irq = 2'b00;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [1:0]  irq_req;
    logic        rd_claim;
    logic [7:0]  rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;
    string tag = "R9";

    // behavioural reference state
    bit m_en[2];
    bit m_held[2];

    always #4 clk = ~clk;

    input_irq_hold dut_i (
        .clk(clk), .rst(rst), .strap_en(strap_en), .en_we(en_we),
        .en_val(en_val), .src_irq(src_irq), .io_rd(io_rd), .io_addr(io_addr),
        .irq_req(irq_req), .rd_claim(rd_claim), .rd_data(rd_data)
    );

    function automatic bit exp_claim();
        return io_rd && io_addr == 16'h0060 && (m_en[0] || m_en[1]);
    endfunction

    task automatic compare();
        logic [1:0] ereq;
        logic       ecl;
        logic [7:0] ed;
        for (int i = 0; i < 2; i++) ereq[i] = m_en[i] ? m_held[i] : src_irq[i];
        ecl = exp_claim();
        ed  = ecl ? 8'hFF : 8'h00;
        n_cmp++;
        if (irq_req !== ereq || rd_claim !== ecl || rd_data !== ed) begin
            n_bad++;
            $display("FAIL %s: req=%b claim=%b data=%h expected req=%b claim=%b data=%h",
                     tag, irq_req, rd_claim, rd_data, ereq, ecl, ed);
        end
    endtask

    task automatic model_edge();
        bit clr;
        clr = exp_claim();
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                m_en[i] = strap_en[i];
                m_held[i] = 0;
            end else begin
                if (en_we[i]) m_en[i] = en_val[i];
                if (!m_en[i]) m_held[i] = 0;
                else if (src_irq[i]) m_held[i] = 1;
                else if (clr) m_held[i] = 0;
            end
        end
    endtask

    // inputs already driven after a falling edge
    task automatic step(input bit chk);
        #1;
        if (chk && !rst) compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        en_we = 0; io_rd = 0; io_addr = 16'h0000;
    endtask

    initial begin
        @(negedge clk);
        step(0); step(0);
        rst = 0;
        tag = "R9"; step(1); step(1);
        // R1 keyboard hold
        tag = "R1"; src_irq = 2'b01; step(1); src_irq = 2'b00; step(1); step(1); step(1);
        // R2 mouse hold
        tag = "R2"; src_irq = 2'b10; step(1); src_irq = 2'b00; step(1); step(1);
        // R10 read elsewhere keeps both
        tag = "R10"; io_rd = 1; io_addr = 16'h0064; step(1); io_addr = 16'h0061; step(1);
        idle(); step(1);
        // R4 claimed read, R3 clears both
        tag = "R4"; io_rd = 1; io_addr = 16'h0060; step(1);
        idle(); tag = "R3"; step(1); step(1);
        // R8 set wins over clear
        tag = "R8"; src_irq = 2'b01; step(1); src_irq = 2'b00; step(1);
        src_irq = 2'b01; io_rd = 1; io_addr = 16'h0060; step(1);
        src_irq = 2'b00; idle(); step(1); step(1);
        // R6 disable keyboard while held
        tag = "R6"; src_irq = 2'b10; step(1); src_irq = 2'b00;
        en_we = 2'b01; en_val = 2'b00; step(1); idle(); step(1); step(1);
        // R7 passthrough on disabled keyboard
        tag = "R7"; src_irq = 2'b01; step(1); src_irq = 2'b00; step(1); src_irq = 2'b01; step(1);
        // R3 read clears only enabled mouse, keyboard source held high
        tag = "R3"; io_rd = 1; io_addr = 16'h0060; step(1); idle(); step(1);
        src_irq = 2'b00; step(1);
        // R5 both disabled: no claim
        tag = "R5"; en_we = 2'b10; en_val = 2'b00; step(1); idle();
        io_rd = 1; io_addr = 16'h0060; step(1); step(1); idle(); step(1);
        // R9 reset with straps off
        tag = "R9"; rst = 1; strap_en = 2'b00; step(0); rst = 0; step(1);
        src_irq = 2'b11; step(1); src_irq = 2'b00; step(1);
        io_rd = 1; io_addr = 16'h0060; step(1); idle(); step(1);
        // random traffic
        tag = "R1 R2 R3 R6 R7 R8 random";
        for (int k = 0; k < 400; k++) begin
            src_irq = 2'($urandom);
            en_we   = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            en_val  = 2'($urandom);
            io_rd   = ($urandom % 3) == 0;
            io_addr = (($urandom % 4) == 0) ? 16'h0064 : 16'h0060;
            step(1);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                n_bad++;
                $display("FAIL watchdog: cycles=%0d expected completion", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end
endmodule